// File: doc/BRIEF.md
# Sticky Event and Masked Interrupt Controller

This block gathers single-cycle hardware event pulses into a 32-bit sticky event register. A bit stays set once its pulse arrives. Software clears it by writing a one to that bit position. A second 32-bit register holds the enables. Each enable bit sits sixteen positions above the event bit it controls, so only events 15..0 can ever be enabled.

The enabled events feed two registered interrupt lines. The error line collects the three memory ECC faults: timestamp FIFO at event bit 13, transmit at bit 9 and receive at bit 8. The normal line carries the magic-packet notification at event bit 14. No other event bit drives either line.

Software reaches both registers through a plain single-cycle register port. There is no stream data in this block, so there is no valid/ready handshake and no back-pressure. A write takes effect at the next clock edge. Read data is a combinational view of the register that `reg_sel` selects.

Top module: `evt_irq_ctrl`

## Requirements
- R1: During and after an active-low reset, the event register reads 0 and both interrupt lines are 0. The enable register reads 0x6300_0000, which sets bits 30, 29, 25 and 24.
- R2: A one on `evt_pulse[i]` at a clock edge sets event bit i at that edge. The bit then stays set, with no further pulses, until it is cleared.
- R3: A write with `reg_sel`=0 clears every event bit whose `reg_wdata` bit is one. Event bits whose `reg_wdata` bit is zero keep their value, so writing 0xFFFF_FFFF clears all pending events.
- R4: When a pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: A write with `reg_sel`=1 loads all 32 bits of the enable register, and they read back unchanged. Such a write leaves the event register unchanged, and a clearing write to the event register leaves the enable register unchanged.
- R6: `irq_err` equals, one clock after the register state, the OR of (event 13 AND enable 29), (event 9 AND enable 25) and (event 8 AND enable 24).
- R7: `irq_norm` equals, one clock after the register state, event 14 AND enable 30.
- R8: Event bits other than 14, 13, 9 and 8 never raise either interrupt line, even with every enable bit set.
- R9: An enable bit affects only the event exactly sixteen positions below it. An ECC or magic-packet event enabled by any other single enable bit raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 = event register, 1 = enable register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data (for the event register, ones mark the bits to clear) |
| reg_rdata | output | 32 | Combinational read of the selected register |
| evt_pulse | input | 32 | One-cycle event pulses, one per event bit |
| irq_err | output | 1 | Registered error interrupt (ECC faults) |
| irq_norm | output | 1 | Registered normal interrupt (magic packet) |

## Verification
The hardest case to reach from the ports is an enable bit that lands on the wrong event. The reset enables already line up with the four interrupt sources, so a wrong offset stays hidden under the default setting. The bench therefore loads every single-bit enable value, one at a time, against each of the four interrupt sources. For each pair it expects an interrupt only when the enable bit sits exactly sixteen above the source. The bench also forces a pulse and a clearing write onto the same bit in the same cycle, which ordinary traffic would rarely line up.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
  localparam int REG_W    = 32;
  localparam int MASK_OFS = 16;

  // interrupt source groups, as event-bit selects
  localparam logic [REG_W-1:0] ERR_EVT_SEL  = (32'd1 << 13) | (32'd1 << 9) | (32'd1 << 8);
  localparam logic [REG_W-1:0] NORM_EVT_SEL = (32'd1 << 14);

  // enables start with every interrupt source on
  localparam logic [REG_W-1:0] MASK_RST_VAL = (ERR_EVT_SEL | NORM_EVT_SEL) << MASK_OFS;

  typedef enum logic {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] evt_q
);
  // set beats clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_vec) | set_vec;
  end

  // R2: bits not cleared stay set
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~clr_vec) != '0) |=>
      ((evt_q & $past(evt_q & ~clr_vec)) == $past(evt_q & ~clr_vec)));

  // R4: pulse wins over clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  // R3: cleared bits without a pulse drop
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((evt_q & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/evt_mask.sv
module evt_mask #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= RST_VAL;
    else if (wr) mask_q <= wdata;
  end

  // R5: enables change only on their own write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q));

  // R5: a write loads the full word
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int               LOW_W = 16,
  parameter logic [LOW_W-1:0] SEL   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOW_W-1:0] evt_low,
  input  logic [LOW_W-1:0] en_high,
  output logic             irq_q
);
  logic [LOW_W-1:0] hits;

  genvar i;
  generate
    for (i = 0; i < LOW_W; i++) begin : g_src
      if (SEL[i]) begin : g_used
        assign hits[i] = evt_low[i] & en_high[i];
      end else begin : g_unused
        assign hits[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |hits;
  end

  // R6/R7: line follows enabled sources one cycle later
  a_r6_r7_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> irq_q);
  a_r6_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |=> !irq_q);
  // R8: unselected positions never contribute
  a_r8_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_low & en_high & SEL) == '0) |=> !irq_q);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evtirq_pkg::*;
#(
  parameter int               W        = REG_W,
  parameter int               OFS      = MASK_OFS,
  parameter logic [W-1:0]     ERR_SEL  = ERR_EVT_SEL,
  parameter logic [W-1:0]     NORM_SEL = NORM_EVT_SEL,
  parameter logic [W-1:0]     MASK_RST = MASK_RST_VAL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         reg_wr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic [31:0]  evt_pulse,
  output logic         irq_err,
  output logic         irq_norm
);
  localparam int LOW_W = W - OFS;

  logic [W-1:0] evt_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] clr_vec;
  logic         wr_evt;
  logic         wr_mask;

  assign wr_evt  = reg_wr && (reg_sel_e'(reg_sel) == SEL_EVENT);
  assign wr_mask = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);
  assign clr_vec = wr_evt ? reg_wdata : '0;

  evt_sticky #(.W(W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_pulse),
    .clr_vec (clr_vec),
    .evt_q   (evt_q)
  );

  evt_mask #(.W(W), .RST_VAL(MASK_RST)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_mask),
    .wdata  (reg_wdata),
    .mask_q (mask_q)
  );

  irq_group #(.LOW_W(LOW_W), .SEL(ERR_SEL[LOW_W-1:0])) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_low (evt_q[LOW_W-1:0]),
    .en_high (mask_q[W-1:OFS]),
    .irq_q   (irq_err)
  );

  irq_group #(.LOW_W(LOW_W), .SEL(NORM_SEL[LOW_W-1:0])) u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_low (evt_q[LOW_W-1:0]),
    .en_high (mask_q[W-1:OFS]),
    .irq_q   (irq_norm)
  );

  assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_MASK) ? mask_q : evt_q;

  // R5: writing the event register leaves enables alone
  a_r5_evt_wr_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> $stable(mask_q));
  // R5: writing enables without pulses leaves events alone
  a_r5_mask_wr_evt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && evt_pulse == '0) |=> $stable(evt_q));
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse = '0;
  logic        irq_err;
  logic        irq_norm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [31:0] MASK_DEF = 32'h6300_0000;

  always #4 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq_err(irq_err), .irq_norm(irq_norm)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_evt(input string req, input logic [31:0] exp);
    reg_sel = 1'b0; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic rd_mask(input string req, input logic [31:0] exp);
    reg_sel = 1'b1; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] v);
    evt_pulse = v;
    tick();
    evt_pulse = '0;
  endtask

  task automatic chk_irq(input string req, input logic e, input logic n);
    chk({req, " err"}, {31'd0, irq_err}, {31'd0, e});
    chk({req, " norm"}, {31'd0, irq_norm}, {31'd0, n});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // R1 during reset
    rd_evt("R1 evt in reset", 32'h0);
    rd_mask("R1 mask in reset", MASK_DEF);
    chk_irq("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    rd_evt("R1 evt after reset", 32'h0);
    rd_mask("R1 mask after reset", MASK_DEF);
    chk_irq("R1 after reset", 1'b0, 1'b0);

    // R2/R3/R6/R7 sweep of every event bit under default enables
    for (int b = 0; b < 32; b++) begin
      logic e, n;
      e = (b == 13) || (b == 9) || (b == 8);
      n = (b == 14);
      pulse(32'd1 << b);
      rd_evt("R2 set", 32'd1 << b);
      chk_irq("R6 R7 not yet", 1'b0, 1'b0);
      tick();
      rd_evt("R2 sticky", 32'd1 << b);
      chk_irq("R6 R7 default mask", e, n);
      wr(1'b0, 32'd1 << b);
      rd_evt("R3 clear one", 32'h0);
      tick();
      chk_irq("R6 R7 after clear", 1'b0, 1'b0);
    end

    // R3 zero bits no effect, partial and full clear
    pulse(32'hFFFF_FFFF);
    wr(1'b0, 32'h0);
    rd_evt("R3 zero write", 32'hFFFF_FFFF);
    wr(1'b0, 32'h0000_FFFF);
    rd_evt("R3 partial", 32'hFFFF_0000);
    wr(1'b0, 32'hFFFF_FFFF);
    rd_evt("R3 clear all", 32'h0);

    // R4 pulse and clear same cycle
    pulse(32'h0000_0020);
    evt_pulse = 32'h0000_2000;
    wr(1'b0, 32'h0000_2020);
    evt_pulse = '0;
    rd_evt("R4 set wins", 32'h0000_2000);
    wr(1'b0, 32'hFFFF_FFFF);

    // R5 mask load and independence
    pulse(32'h0000_1234);
    wr(1'b1, 32'hA5A5_5A5A);
    rd_mask("R5 mask readback", 32'hA5A5_5A5A);
    rd_evt("R5 evt untouched", 32'h0000_1234);
    wr(1'b0, 32'hFFFF_FFFF);
    rd_mask("R5 mask untouched", 32'hA5A5_5A5A);
    rd_evt("R5 evt cleared", 32'h0);

    // R8 non-source events with all enables
    wr(1'b1, 32'hFFFF_FFFF);
    pulse(~32'h0000_6300);
    tick();
    chk_irq("R8 non-source", 1'b0, 1'b0);
    pulse(32'h0000_6300);
    tick();
    chk_irq("R6 R7 all on", 1'b1, 1'b1);
    wr(1'b0, 32'hFFFF_FFFF);
    wr(1'b1, 32'h0000_FFFF);
    pulse(32'hFFFF_FFFF);
    tick();
    chk_irq("R9 low enables", 1'b0, 1'b0);
    wr(1'b0, 32'hFFFF_FFFF);
    tick();

    // R9 every single enable bit against every source
    for (int si = 0; si < 4; si++) begin
      int s;
      s = (si == 0) ? 8 : (si == 1) ? 9 : (si == 2) ? 13 : 14;
      for (int m = 0; m < 32; m++) begin
        logic e, n;
        e = (s != 14) && (m == s + 16);
        n = (s == 14) && (m == 30);
        wr(1'b1, 32'd1 << m);
        pulse(32'd1 << s);
        tick();
        chk_irq("R9 offset sweep", e, n);
        wr(1'b0, 32'd1 << s);
        tick();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule